// File: doc/BRIEF.md
# Streaming Two-Point Butterfly Stage

This block takes one complex sample on each cycle where the clock enable is high and groups consecutive samples in time into pairs. For each pair it first puts out the complex sum and then, on the next enabled cycle, the complex difference. Both appear on one output port, and each component gains one bit of width. Stages of this kind form the last radix-2 step of a streaming transform, where neighbouring samples in time are the two butterfly inputs.

A frame marker on the input names the first sample of a frame. That sample always opens a new pair, even when it arrives halfway through a pair. The marker travels through a delay line of fixed length and leaves the block together with the sum of the first pair of the frame. Every register moves only when the clock enable is high. A synchronous active-high reset clears the pairing state, the arithmetic registers, the output delay and the marker delay.

Pairing is run by a two-state controller. In `PH_FIRST` the block waits for the first element of a pair. In `PH_SECOND` it waits for the second element. The transitions are taken on enabled cycles only:
- `PH_FIRST` to `PH_SECOND` on any enabled sample.
- `PH_SECOND` to `PH_FIRST` when an enabled sample arrives without the marker. This closes the pair.
- `PH_SECOND` to `PH_SECOND` when a marked sample arrives. This realigns the pairing: the pending first element is dropped and the marked sample becomes the new first element.
- Reset forces `PH_FIRST`.

Top module: `butterfly_stage`

## Requirements
- R1: The input word packs the real part as a signed 16-bit value in bits 31:16 and the imaginary part as a signed 16-bit value in bits 15:0.
- R2: The output word packs the real part as a signed 17-bit value in bits 33:17 and the imaginary part as a signed 17-bit value in bits 16:0.
- R3: For a pair (first, second), the first output is first+second, formed separately for the real and the imaginary parts.
- R4: On the enabled cycle after the sum, the output is the difference first−second, formed separately for the real and the imaginary parts.
- R5: If the first element of a pair is taken on enabled cycle n, the sum is on the output after the edge of enabled cycle n+4 and the difference after the edge of enabled cycle n+5.
- R6: The sync output is high after the edge of enabled cycle k+4 exactly when the sync input was high on enabled cycle k. It is low otherwise, and it coincides with the sum of the first pair of the frame.
- R7: On a cycle with clock enable low, the data output and the sync output keep their values, and no input sample is taken.
- R8: Reset clears the block, so that the data output is zero and the sync output is low. After reset, both stay at zero and low for the first four enabled cycles, until the first pair has come through.
- R9: Sums and differences keep full precision through sign extension to 17 bits, with no rounding or wrap. For example, −32768+−32768 gives −65536, and 32767−(−32768) gives 65535.
- R10: A sync input on the second element of a pair drops the pending first element, and the marked sample becomes the first element of a new pair. That pair then follows R3 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; the whole stage advances only when high |
| sync_in | input | 1 | Marks the first sample of a frame |
| din | input | 32 | Complex input sample {real[15:0], imag[15:0]} |
| dout | output | 34 | Complex output {real[16:0], imag[16:0]}, sum then difference |
| sync_out | output | 1 | Marks the sum of the first pair of a frame |

## Verification
The frame marker can arrive on the same enabled cycle that would otherwise close a pair. In that cycle the realignment and the pair completion compete, and the realignment must win: no sum is produced from the dropped first element. The bench provokes this by sending a marker, one sample, then a second marker. It judges the outcome with a reference model that pairs samples independently and expects the sum of the realigned pair exactly on the cycle the sync output rises. Stalled cycles are mixed in with the enabled cycles, so the model's enabled-cycle count is tested against the design's fixed latency.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    // Pairing phase of the streaming butterfly
    typedef enum logic {
        PH_FIRST  = 1'b0,   // waiting for first element of a pair
        PH_SECOND = 1'b1    // waiting for second element of a pair
    } pair_phase_t;

endpackage

// File: rtl/bfly_pair_ctl.sv
module bfly_pair_ctl
    import bfly_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic sync_in,
    output logic load_first,
    output logic close_pair
);

    pair_phase_t state;
    pair_phase_t nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PH_FIRST;
        end else if (ce) begin
            state <= nxt;
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            PH_FIRST:  nxt = PH_SECOND;
            PH_SECOND: nxt = sync_in ? PH_SECOND : PH_FIRST;
            default:   nxt = PH_FIRST;
        endcase
    end

    // Outputs
    always_comb begin
        load_first = 1'b0;
        close_pair = 1'b0;
        unique case (state)
            PH_FIRST: begin
                load_first = ce;
            end
            PH_SECOND: begin
                load_first = ce && sync_in;
                close_pair = ce && !sync_in;
            end
            default: begin
                load_first = 1'b0;
                close_pair = 1'b0;
            end
        endcase
    end

    AST_SYNC_REALIGN: assert property (@(posedge clk) disable iff (rst)
        (ce && sync_in) |=> (state == PH_SECOND)); // R10

    AST_PAIR_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (ce && !sync_in && state == PH_SECOND) |=> (state == PH_FIRST)); // R3

endmodule

// File: rtl/bfly_arith.sv
module bfly_arith #(
    parameter int IW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              load_first,
    input  logic              close_pair,
    input  logic [2*IW-1:0]   din,
    output logic [2*IW+1:0]   y
);

    localparam int OW = IW + 1;

    logic signed [IW-1:0] in_re, in_im;
    logic signed [IW-1:0] fst_re, fst_im;
    logic signed [OW-1:0] sum_re, sum_im, dif_re, dif_im;
    logic signed [OW-1:0] add_re, add_im, sub_re, sub_im;
    logic                 pv;

    assign in_re = din[2*IW-1:IW];
    assign in_im = din[IW-1:0];

    // Full-precision sign-extended arithmetic
    assign add_re = {fst_re[IW-1], fst_re} + {in_re[IW-1], in_re};
    assign add_im = {fst_im[IW-1], fst_im} + {in_im[IW-1], in_im};
    assign sub_re = {fst_re[IW-1], fst_re} - {in_re[IW-1], in_re};
    assign sub_im = {fst_im[IW-1], fst_im} - {in_im[IW-1], in_im};

    always_ff @(posedge clk) begin
        if (rst) begin
            fst_re <= '0;
            fst_im <= '0;
            sum_re <= '0;
            sum_im <= '0;
            dif_re <= '0;
            dif_im <= '0;
            pv     <= 1'b0;
            y      <= '0;
        end else if (ce) begin
            if (load_first) begin
                fst_re <= in_re;
                fst_im <= in_im;
            end
            if (close_pair) begin
                sum_re <= add_re;
                sum_im <= add_im;
                dif_re <= sub_re;
                dif_im <= sub_im;
            end
            pv <= close_pair;
            // Serialise: sum on the slot after completion, difference next
            y  <= pv ? {sum_re, sum_im} : {dif_re, dif_im};
        end
    end

    AST_PAIR_IDENT: assert property (@(posedge clk) disable iff (rst)
        pv |-> ((({sum_re[OW-1], sum_re} + {dif_re[OW-1], dif_re}) == {fst_re[IW-1], fst_re, 1'b0})
             && (({sum_im[OW-1], sum_im} + {dif_im[OW-1], dif_im}) == {fst_im[IW-1], fst_im, 1'b0}))); // R4

    AST_SER_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(y)); // R7

endmodule

// File: rtl/bfly_delay.sv
module bfly_delay #(
    parameter int W     = 1,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] st [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                st[i] <= '0;
            end
        end else if (en) begin
            st[0] <= d;
            for (int i = 1; i < DEPTH; i++) begin
                st[i] <= st[i-1];
            end
        end
    end

    assign q = st[DEPTH-1];

    AST_DLY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q)); // R7

endmodule

// File: rtl/butterfly_stage.sv
module butterfly_stage #(
    parameter int IW      = 16,
    parameter int LATENCY = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ce,
    input  logic                sync_in,
    input  logic [2*IW-1:0]     din,
    output logic [2*IW+1:0]     dout,
    output logic                sync_out
);

    localparam int OW   = IW + 1;
    localparam int DW   = 2 * OW;
    localparam int TAIL = LATENCY - 2;

    logic          load_first;
    logic          close_pair;
    logic [DW-1:0] ser;

    bfly_pair_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .ce         (ce),
        .sync_in    (sync_in),
        .load_first (load_first),
        .close_pair (close_pair)
    );

    bfly_arith #(.IW(IW)) u_arith (
        .clk        (clk),
        .rst        (rst),
        .ce         (ce),
        .load_first (load_first),
        .close_pair (close_pair),
        .din        (din),
        .y          (ser)
    );

    generate
        if (TAIL > 0) begin : g_tail
            bfly_delay #(.W(DW), .DEPTH(TAIL)) u_dtail (
                .clk (clk),
                .rst (rst),
                .en  (ce),
                .d   (ser),
                .q   (dout)
            );
        end else begin : g_notail
            assign dout = ser;
        end
    endgenerate

    bfly_delay #(.W(1), .DEPTH(LATENCY + 1)) u_sync (
        .clk (clk),
        .rst (rst),
        .en  (ce),
        .d   (sync_in),
        .q   (sync_out)
    );

    AST_SYNC_GATED: assert property (@(posedge clk) disable iff (rst)
        (!ce && !sync_out) |=> !sync_out); // R6

endmodule

// File: tb/tb_butterfly_stage.sv
module tb_butterfly_stage;

    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic        ce = 1'b0;
    logic        sync_in = 1'b0;
    logic [31:0] din = '0;
    logic [33:0] dout;
    logic        sync_out;

    int errors = 0;
    int checks = 0;

    // Reference model state
    logic [33:0]        exp_d [2048];
    bit                 exp_v [2048];
    bit                 sy    [2048];
    int                 idx = 0;
    bit                 phase = 1'b0;
    logic signed [15:0] fr, fi;

    always #5 clk = ~clk;

    butterfly_stage dut (
        .clk      (clk),
        .rst      (rst),
        .ce       (ce),
        .sync_in  (sync_in),
        .din      (din),
        .dout     (dout),
        .sync_out (sync_out)
    );

    task automatic check(input string req, input logic [33:0] act, input logic [33:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h (idx %0d)", req, act, expv, idx);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 2048; i++) begin
            exp_v[i] = 1'b0;
            sy[i]    = 1'b0;
            exp_d[i] = '0;
        end
        idx   = 0;
        phase = 1'b0;
    endtask

    // One clock: drive at negedge, sample after the edge
    task automatic step(input bit c, input bit s, input logic signed [15:0] r,
                        input logic signed [15:0] i, input string tag);
        logic [33:0]        pd;
        logic               ps;
        logic signed [16:0] sr, si, dr, di;
        @(negedge clk);
        ce = c; sync_in = s; din = {r, i};   // R1 packing
        pd = dout; ps = sync_out;
        @(posedge clk);
        #1;
        if (!c) begin
            check("R7 dout hold", dout, pd);
            check("R7 sync hold", {33'b0, sync_out}, {33'b0, ps});
        end else begin
            sy[idx] = s;
            if (s || !phase) begin
                fr = r; fi = i; phase = 1'b1;
            end else begin
                sr = {fr[15], fr} + {r[15], r};
                si = {fi[15], fi} + {i[15], i};
                dr = {fr[15], fr} - {r[15], r};
                di = {fi[15], fi} - {i[15], i};
                if (idx + 4 < 2048) begin
                    exp_d[idx+3] = {sr, si}; exp_v[idx+3] = 1'b1;   // R2 packing
                    exp_d[idx+4] = {dr, di}; exp_v[idx+4] = 1'b1;
                end
                phase = 1'b0;
            end
            if (exp_v[idx])
                check(tag, dout, exp_d[idx]);
            else if (idx < 4)
                check("R8 zero until data", dout, 34'b0);
            check("R6 sync_out", {33'b0, sync_out},
                  {33'b0, (idx >= 4) ? sy[idx-4] : 1'b0});
            idx++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; ce = 1'b1; sync_in = 1'b1; din = 32'h7fff_8000;
        @(posedge clk); @(negedge clk);
        @(posedge clk); #1;
        check("R8 reset dout", dout, 34'b0);
        check("R8 reset sync_out", {33'b0, sync_out}, 34'b0);
        @(negedge clk);
        rst = 1'b0; ce = 1'b0; sync_in = 1'b0;
        model_clear();
        // Samples right after reset: output stays zero for four enabled cycles
        step(1, 0, 16'sd100, -16'sd7, "R8/R3/R5");
        step(1, 0, 16'sd20, 16'sd3, "R8/R3/R5");
        step(1, 0, 16'sd0, 16'sd0, "R8/R3/R5");
        step(1, 0, 16'sd0, 16'sd0, "R8/R3/R5");
        step(1, 0, 16'sd0, 16'sd0, "R3/R5 first sum");
        step(1, 0, 16'sd0, 16'sd0, "R4/R5 first diff");
    endtask

    task automatic t_frame();
        step(1, 1, 16'sd1234, -16'sd4321, "R1/R2/R3/R4/R5");
        for (int k = 0; k < 15; k++)
            step(1, 0, 16'($urandom), 16'($urandom), "R1/R2/R3/R4/R5");
        for (int k = 0; k < 5; k++)
            step(1, 0, 16'sd0, 16'sd0, "R3/R4/R5 flush");
    endtask

    task automatic t_extremes();
        step(1, 1, -16'sd32768, -16'sd32768, "R9");
        step(1, 0, -16'sd32768, -16'sd32768, "R9");
        step(1, 0, 16'sd32767, -16'sd32768, "R9");
        step(1, 0, -16'sd32768, 16'sd32767, "R9");
        step(1, 0, 16'sd32767, 16'sd32767, "R9");
        step(1, 0, 16'sd32767, 16'sd32767, "R9");
        for (int k = 0; k < 5; k++)
            step(1, 0, 16'sd0, 16'sd0, "R9 flush");
    endtask

    task automatic t_stall();
        step(1, 1, 16'sd500, 16'sd60, "R7/R6");
        step(0, 1, 16'sd9999, 16'sd9999, "R7");
        step(1, 0, -16'sd200, 16'sd40, "R7/R3");
        for (int k = 0; k < 10; k++) begin
            step(0, (k % 3) == 0, 16'($urandom), 16'($urandom), "R7");
            step(1, 0, 16'($urandom), 16'($urandom), "R7/R3/R4/R5");
        end
        for (int k = 0; k < 5; k++) begin
            step(0, 0, 16'sd1, 16'sd1, "R7");
            step(1, 0, 16'sd0, 16'sd0, "R7 flush");
        end
    endtask

    task automatic t_realign();
        step(1, 1, 16'sd111, 16'sd222, "R10");
        step(1, 1, 16'sd300, -16'sd50, "R10");
        step(1, 0, 16'sd25, 16'sd75, "R10");
        step(1, 0, 16'sd8, 16'sd9, "R10");
        step(1, 1, -16'sd1000, 16'sd1000, "R10");
        step(1, 0, 16'sd1, -16'sd1, "R10");
        for (int k = 0; k < 6; k++)
            step(1, 0, 16'sd0, 16'sd0, "R10 flush");
    endtask

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_clear();
        t_reset();
        t_frame();
        t_extremes();
        t_stall();
        t_realign();
        t_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule